// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block drives four pulse-width modulated outputs from a single clock. A word-addressed register bus with a one-cycle write strobe and a combinational read port sets up the channels. Two 8-bit prescalers each serve one pair of channels: the low byte serves channels 0 and 1, and the high byte serves channels 2 and 3. Behind its prescaler, each channel has its own power-of-two divider, a down-counter with period and compare values, and enable, invert and mode bits.

Each channel counts down from its period value to zero, one step per channel tick, and then reloads. Its output is high during the first (compare + 1) ticks of each period. Period and compare values written while a channel runs take effect only at the next reload. A read-back register returns the live count. A channel set to one-shot runs a single period and then holds low until software re-enables it.

Top module: `pwm4_top`

## Requirements
- R1: The word addresses are: 0 prescale, 1 clock select, 2 control. Channel n uses 3+3n for period, 4+3n for compare and 5+3n for live count. The prescale, clock-select, control, period and compare registers read back what was written, with unimplemented bits masked: clock select keeps bits 0–2 of each nibble. Writes to count registers and unmapped addresses are ignored, and unmapped addresses read 0.
- R2: A running channel's period lasts (period + 1) channel ticks. The output is high for the first (compare + 1) of those ticks.
- R3: When compare is greater than or equal to a non-zero period, the non-inverted output is high for the whole period.
- R4: A zero period, or a cleared enable bit, gives a constantly low non-inverted output.
- R5: The invert bit complements the output in every case, including the disabled and zero-period cases.
- R6: Prescale bits 0–7 serve channels 0 and 1, and bits 8–15 serve channels 2 and 3. A field value p gives one prescaled tick every p+1 clocks.
- R7: Clock-select code c in bits [4n+2:4n] sets the channel n tick. Codes 0 to 3 give one tick every 2^(c+1) prescaled ticks. Code 4 and codes 5 to 7 give one tick per prescaled tick.
- R8: In the control register, channel n uses bit 0 for enable, bit 2 for invert and bit 3 for mode, at field offsets 0, 8, 12 and 16. Mode 1 repeats periods. Mode 0 runs one period, then holds the output low with the count at 0 until enable is cleared and set again.
- R9: A compare or period value written while a channel runs is used only from the next reload.
- R10: The count register returns the live down-count. Clearing enable stops it and returns it to 0. Setting enable restarts the count from the full period value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | Channel waveforms, bit n for channel n |

## Verification
A write lands in its register at the clock edge that samples the strobe. A channel that is being enabled loads its count at the next edge, so its first output level is valid from the following low clock phase. The scoreboard queues its expected levels only after the write task returns, so the monitor's first pop falls in that phase. Invert takes effect on the output in the cycle of the write. Disabling clears the count one edge after the control register updates, so those reads wait one extra cycle. Prescaler phase is free-running, so divided-clock checks count high samples and rising edges over whole periods after a settling time rather than matching levels cycle by cycle.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
    localparam int NCH    = 4;
    localparam int NPAIR  = NCH / 2;
    localparam int CNT_W  = 16;
    localparam int PSC_W  = 8;
    localparam int ADDR_W = 5;
    localparam int DW     = 32;
    localparam int SEL_W  = 3;

    localparam int A_PSC = 0;
    localparam int A_SEL = 1;
    localparam int A_CTL = 2;
    localparam int A_CH0 = 3;

    // control field offsets per channel: 0, 8, 12, 16
    function automatic int ctl_off(int ch);
        return (ch == 0) ? 0 : 4 + 4 * ch;
    endfunction

    localparam int CTL_W = ctl_off(NCH - 1) + 4;

    function automatic logic [CTL_W-1:0] ctl_mask();
        logic [CTL_W-1:0] m = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            m[ctl_off(ch)]     = 1'b1;
            m[ctl_off(ch) + 2] = 1'b1;
            m[ctl_off(ch) + 3] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [4*NCH-1:0] sel_mask();
        logic [4*NCH-1:0] m = '0;
        for (int ch = 0; ch < NCH; ch++) m[4*ch +: SEL_W] = '1;
        return m;
    endfunction

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic             en;
        logic             inv;
        logic             cont;
        logic [SEL_W-1:0] sel;
        cnt_t             period;
        cnt_t             compare;
    } chan_cfg_t;

    typedef struct packed {
        logic [NPAIR*PSC_W-1:0] psc;
        logic [4*NCH-1:0]       sel;
        logic [CTL_W-1:0]       ctl;
        cnt_t [NCH-1:0]         per;
        cnt_t [NCH-1:0]         cmp;
    } reg_file_t;

    typedef struct packed {
        logic       run;
        logic       done;
        logic [3:0] div;
        cnt_t       cnt;
        cnt_t       per;
        cnt_t       cmp;
    } chan_state_t;
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
    import pwm4_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DW-1:0]          wdata_i,
    input  cnt_t [NCH-1:0]         live_i,
    output logic [DW-1:0]          rdata_o,
    output chan_cfg_t [NCH-1:0]    cfg_o,
    output logic [NPAIR*PSC_W-1:0] psc_o,
    output logic                   psc_wr_o
);
    reg_file_t r_d, r_q;
    logic      unused_wbits;

    assign unused_wbits = ^wdata_i[DW-1:CTL_W];

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            if (addr_i == ADDR_W'(A_PSC)) r_d.psc = wdata_i[NPAIR*PSC_W-1:0];
            if (addr_i == ADDR_W'(A_SEL)) r_d.sel = wdata_i[4*NCH-1:0] & sel_mask();
            if (addr_i == ADDR_W'(A_CTL)) r_d.ctl = wdata_i[CTL_W-1:0] & ctl_mask();
            for (int ch = 0; ch < NCH; ch++) begin
                if (addr_i == ADDR_W'(A_CH0 + 3*ch))     r_d.per[ch] = wdata_i[CNT_W-1:0];
                if (addr_i == ADDR_W'(A_CH0 + 3*ch + 1)) r_d.cmp[ch] = wdata_i[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(A_PSC)) rdata_o = DW'(r_q.psc);
        if (addr_i == ADDR_W'(A_SEL)) rdata_o = DW'(r_q.sel);
        if (addr_i == ADDR_W'(A_CTL)) rdata_o = DW'(r_q.ctl);
        for (int ch = 0; ch < NCH; ch++) begin
            if (addr_i == ADDR_W'(A_CH0 + 3*ch))     rdata_o = DW'(r_q.per[ch]);
            if (addr_i == ADDR_W'(A_CH0 + 3*ch + 1)) rdata_o = DW'(r_q.cmp[ch]);
            if (addr_i == ADDR_W'(A_CH0 + 3*ch + 2)) rdata_o = DW'(live_i[ch]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign psc_o    = r_q.psc;
    assign psc_wr_o = wr_i && (addr_i == ADDR_W'(A_PSC));

    for (genvar g = 0; g < NCH; g++) begin : g_cfg
        localparam int OFF = ctl_off(g);
        assign cfg_o[g].en      = r_q.ctl[OFF];
        assign cfg_o[g].inv     = r_q.ctl[OFF + 2];
        assign cfg_o[g].cont    = r_q.ctl[OFF + 3];
        assign cfg_o[g].sel     = r_q.sel[4*g +: SEL_W];
        assign cfg_o[g].period  = r_q.per[g];
        assign cfg_o[g].compare = r_q.cmp[g];
    end

    // R1: a period write shows up on the channel configuration one edge later
    a_r1_period_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(A_CH0)) |=> cfg_o[0].period == $past(wdata_i[CNT_W-1:0]));
endmodule

// File: rtl/pwm4_prescale.sv
module pwm4_prescale #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div_i,
    input  logic         restart_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = !restart_i && (cnt_q >= div_i);
        if (restart_i || tick_o) cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: each prescaled tick starts a fresh count
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> cnt_q == '0);
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
    import pwm4_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg_i,
    input  logic      pre_tick_i,
    output cnt_t      live_o,
    output logic      wave_o
);
    chan_state_t s_d, s_q;
    logic        tick;
    logic        raw;
    logic [3:0]  dmask;

    always_comb begin
        case (cfg_i.sel)
            3'd0:    dmask = 4'h1;
            3'd1:    dmask = 4'h3;
            3'd2:    dmask = 4'h7;
            3'd3:    dmask = 4'hF;
            default: dmask = 4'h0;
        endcase
        tick = pre_tick_i && ((s_q.div & dmask) == dmask);
    end

    always_comb begin
        s_d = s_q;
        if (!cfg_i.en) begin
            s_d.run  = 1'b0;
            s_d.done = 1'b0;
            s_d.div  = '0;
            s_d.cnt  = '0;
        end else if (!s_q.run && !s_q.done) begin
            s_d.run = 1'b1;
            s_d.div = '0;
            s_d.cnt = cfg_i.period;
            s_d.per = cfg_i.period;
            s_d.cmp = cfg_i.compare;
        end else if (s_q.run) begin
            if (pre_tick_i) s_d.div = s_q.div + 1'b1;
            if (tick) begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (cfg_i.cont) begin
                    s_d.cnt = cfg_i.period;
                    s_d.per = cfg_i.period;
                    s_d.cmp = cfg_i.compare;
                end else begin
                    s_d.run  = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign raw    = s_q.run && (s_q.per != '0) &&
                    ((s_q.cmp >= s_q.per) || (s_q.cnt >= s_q.per - s_q.cmp));
    assign wave_o = raw ^ cfg_i.inv;
    assign live_o = s_q.cnt;

    // R4: a cleared enable leaves the channel stopped and low
    a_r4_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> (!raw && s_q.cnt == '0));
    // R2: the live count never exceeds the latched period
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> s_q.cnt <= s_q.per);
    // R9: latched period and compare move only at a reload
    a_r9_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && cfg_i.en && !tick) |=> ($stable(s_q.per) && $stable(s_q.cmp)));
    // R8: a finished one-shot stays finished and low while enabled
    a_r8_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && cfg_i.en) |=> (s_q.done && !raw));
endmodule

// File: rtl/pwm4_top.sv
module pwm4_top
    import pwm4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    chan_cfg_t [NCH-1:0]    cfg;
    cnt_t [NCH-1:0]         live;
    logic [NPAIR*PSC_W-1:0] psc;
    logic                   psc_wr;
    logic [NPAIR-1:0]       pre_tick;

    pwm4_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .live_i  (live),
        .rdata_o (bus_rdata),
        .cfg_o   (cfg),
        .psc_o   (psc),
        .psc_wr_o(psc_wr)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pwm4_prescale #(.W(PSC_W)) u_psc (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_i    (psc[p*PSC_W +: PSC_W]),
            .restart_i(psc_wr),
            .tick_o   (pre_tick[p])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm4_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_i     (cfg[c]),
            .pre_tick_i(pre_tick[c/2]),
            .live_o    (live[c]),
            .wave_o    (pwm_out[c])
        );
    end
endmodule

// File: tb/pwm4_top_test.sv
module pwm4_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [3:0] mask;
        logic [3:0] exp;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    pwm4_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // monitor: one expected level set per low clock phase
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if ((pwm_out & it.mask) !== (it.exp & it.mask)) begin
                fails++;
                $display("FAIL %s pwm_out actual=%b expected=%b mask=%b",
                         it.tag, pwm_out, it.exp, it.mask);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        bus_wr = 1'b1; bus_addr = 5'(addr); bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input int addr, input logic [31:0] exp, input string tag);
        bus_addr = 5'(addr);
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s read addr %0d actual=%h expected=%h", tag, addr, bus_rdata, exp);
        end
    endtask

    task automatic push(input string tag, input logic [3:0] mask,
                        input logic [3:0] exp, input int n);
        for (int i = 0; i < n; i++) sb.push_back('{tag, mask, exp});
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic measure(input int ch, input int n, input int exp_hi,
                           input int exp_rise, input string tag);
        int hi = 0;
        int rs = 0;
        logic prev;
        @(negedge clk);
        prev = pwm_out[ch];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
            if (pwm_out[ch] && !prev) rs++;
            prev = pwm_out[ch];
        end
        checks++;
        if (hi != exp_hi || rs != exp_rise) begin
            fails++;
            $display("FAIL %s ch%0d highs/rises actual=%0d/%0d expected=%0d/%0d",
                     tag, ch, hi, rs, exp_hi, exp_rise);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state: R4 low outputs, R1 zeroed registers
        push("R4 reset", 4'hF, 4'h0, 1);
        drain();
        rd_chk(2, 32'h0, "R1 reset ctl");
        rd_chk(5, 32'h0, "R10 reset count");

        // R1 map and masking
        wr(1, 32'hFFFF_FFFF);
        rd_chk(1, 32'h0000_7777, "R1 sel mask");
        wr(2, 32'hFFFF_FFFF);
        rd_chk(2, 32'h000D_DD0D, "R1 ctl mask");
        wr(2, 32'h0);
        wr(1, 32'h0000_4444);
        wr(0, 32'h0);
        wr(15, 32'hFFFF_FFFF);
        rd_chk(15, 32'h0, "R1 unmapped");
        wr(5, 32'h1234);
        rd_chk(5, 32'h0, "R1 count write ignored");
        wr(3, 32'd4);
        rd_chk(3, 32'd4, "R1 period readback");

        // R2: period 4, compare 1 -> HHLLL
        wr(4, 32'd1);
        wr(2, 32'h9);
        #1;
        for (int k = 0; k < 3; k++) begin
            push("R2 wave", 4'h1, 4'h1, 2);
            push("R2 wave", 4'h1, 4'h0, 3);
        end
        drain();

        // R3: compare above period -> always high
        wr(6, 32'd3);
        wr(7, 32'd5);
        wr(2, 32'h909);
        #1;
        push("R3 full high", 4'h2, 4'h2, 8);
        drain();

        // R5 on full-high, R4 zero period on ch2
        wr(9, 32'd0);
        wr(10, 32'd0);
        wr(2, 32'h9D09);
        #1;
        push("R5 invert full / R4 zero period", 4'h6, 4'h0, 6);
        drain();
        wr(2, 32'h4DD09);
        #1;
        push("R5 invert zero period and disabled", 4'hE, 4'hC, 6);
        drain();

        // R9: compare change mid-period applies at reload
        wr(2, 32'h9);
        wr(4, 32'd1);
        begin
            bit hit = 0;
            for (int i = 0; i < 40 && !hit; i++) begin
                @(negedge clk);
                bus_addr = 5'd5;
                #1;
                if (bus_rdata == 32'd2) hit = 1;
            end
            checks++;
            if (!hit) begin
                fails++;
                $display("FAIL R10 count never reached 2 actual=%0d expected=2", bus_rdata);
            end
        end
        wr(4, 32'd4);
        #1;
        push("R9 old compare kept", 4'h1, 4'h0, 1);
        push("R9 new compare at reload", 4'h1, 4'h1, 6);
        drain();

        // R10: disable clears, re-enable restarts at full period
        wr(2, 32'h0);
        @(negedge clk);
        rd_chk(5, 32'h0, "R10 disabled count");
        checks++;
        if (pwm_out[0] !== 1'b0) begin
            fails++;
            $display("FAIL R4 disabled output actual=%b expected=0", pwm_out[0]);
        end
        wr(3, 32'd9);
        wr(2, 32'h9);
        @(negedge clk);
        rd_chk(5, 32'd9, "R10 restart count");
        @(negedge clk);
        rd_chk(5, 32'd8, "R10 live count");

        // R6/R7: prescale pairs and dividers
        wr(2, 32'h0);
        wr(0, 32'h0000_0002);
        wr(1, 32'h0000_4370);
        wr(3, 32'd3); wr(4, 32'd0);
        wr(6, 32'd3); wr(7, 32'd1);
        wr(9, 32'd1); wr(10, 32'd0);
        wr(2, 32'h9909);
        repeat (70) @(negedge clk);
        measure(0, 48, 12, 2, "R6 R7 prescale 3 div 2");
        measure(1, 24, 12, 2, "R7 code 7 undivided");
        measure(2, 64, 32, 2, "R6 R7 high byte, div 16");

        // R8: one-shot on ch3
        wr(2, 32'h0);
        wr(12, 32'd2);
        wr(13, 32'd0);
        wr(2, 32'h10000);
        #1;
        push("R8 one-shot", 4'h8, 4'h8, 1);
        push("R8 one-shot", 4'h8, 4'h0, 7);
        drain();
        rd_chk(14, 32'h0, "R8 one-shot count held");
        wr(2, 32'h0);
        wr(2, 32'h10000);
        #1;
        push("R8 re-enable", 4'h8, 4'h8, 1);
        push("R8 re-enable", 4'h8, 4'h0, 4);
        drain();

        finish_run();
    end
endmodule